// File: doc/BRIEF.md
# Speculative Read-After-Write Conflict Tracker

This block watches the memory traffic of a small set of speculative threads that run a sequential program out of order. Every thread slot is started with a sequence rank that records its place in program order. Each read or write a thread performs is reported on a single operation port, together with the slot number and a small word index naming one of the tracked locations.

For each slot, the block remembers which locations the thread read before writing them itself, and which it has written. When a thread earlier in program order writes a location that a later thread has already consumed, that later thread has used a stale value. The block then raises a restart pulse for it and wipes its tracking state. A predictor match flag on the write suppresses the restart when the value the later thread speculated on turns out to equal the new one.

Threads retire in program order. A commit request is granted only for the oldest live slot, and any other request is answered with an error pulse. A squash frees a slot and drops its state without any restart. Each slot runs a two-state machine, `SL_FREE` and `SL_LIVE`, with these transitions:
- `T_START` takes a slot from `SL_FREE` to `SL_LIVE`.
- `T_RETIRE` (a granted commit) and `T_SQUASH` take it from `SL_LIVE` back to `SL_FREE`.
- `T_RESTART` takes `SL_LIVE` back to `SL_LIVE` and clears the slot's marks.
- `T_TRACK` takes `SL_LIVE` back to `SL_LIVE` and records a read or write.

Top module: `spec_dep_tracker`

## Requirements
- R1: After reset, no slot is live and `restart_o`, `commit_ok_o` and `commit_err_o` are all zero.
- R2: A start operation (`op_kind`=1) on a free slot makes it live one cycle later and gives it a rank later than every rank handed out before. A start on a slot that is already live has no effect.
- R3: A write (`op_kind`=3) to word A, by a slot ranked earlier than a live slot S, sets bit S of `restart_o` for exactly one cycle, in the cycle after the write. This happens when S read A (`op_kind`=2) while it had not yet written A, and `op_match` is low. S stays live.
- R4: A write never raises a restart for a slot ranked earlier than the writer, nor for the writer itself.
- R5: A slot that wrote word A before its first read of A is not restarted by later writes to A from earlier-ranked slots.
- R6: A restart clears all read and write marks of the restarted slot. A second earlier-ranked write to the same word does not restart it again unless it has read that word anew.
- R7: A write with `op_match` high raises no restart.
- R8: A commit (`op_kind`=4) on the oldest live slot pulses `commit_ok_o` one cycle later and frees the slot.
- R9: A commit on a slot that is free, or that is not the oldest live slot, pulses `commit_err_o` one cycle later and leaves every slot unchanged.
- R10: A squash (`op_kind`=5) frees a live slot and clears its marks, with no restart pulse.
- R11: Reads and writes issued for a free slot are ignored. They neither mark that slot nor restart any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | 1 start, 2 read, 3 write, 4 commit, 5 squash |
| op_tid | input | $clog2(NTHR) | Slot the operation belongs to |
| op_addr | input | $clog2(NADDR) | Tracked word index for reads and writes |
| op_match | input | 1 | On a write: the value predicted for later readers equals the written value |
| live_o | output | NTHR | One bit per slot that is live |
| restart_o | output | NTHR | One-cycle restart pulse per violated slot |
| commit_ok_o | output | 1 | Commit granted |
| commit_err_o | output | 1 | Commit refused |

## Verification
Every operation takes effect at the first rising edge after it is presented, so `live_o`, `restart_o` and both commit pulses are due exactly one cycle after the operation. Each restart or commit pulse lasts only that one cycle. The bench applies each operation just after a falling edge and compares all four outputs at the next falling edge. This falls after the single register stage and before the following operation can change anything. An idle cycle is checked the same way, to show that pulses have dropped.

// File: rtl/spec_dep_pkg.sv
package spec_dep_pkg;

    typedef enum logic [2:0] {
        OPK_IDLE   = 3'd0,
        OPK_START  = 3'd1,
        OPK_READ   = 3'd2,
        OPK_WRITE  = 3'd3,
        OPK_COMMIT = 3'd4,
        OPK_SQUASH = 3'd5
    } opk_t;

    typedef enum logic {
        SL_FREE = 1'b0,
        SL_LIVE = 1'b1
    } slot_st_t;

endpackage

// File: rtl/spec_dep_order.sv
// Rank comparison: which live slot is oldest, and which slots follow the writer.
module spec_dep_order #(
    parameter int NTHR = 4,
    parameter int RW   = 8,
    localparam int TW  = $clog2(NTHR)
) (
    input  logic [NTHR-1:0]         live,
    input  logic [NTHR-1:0][RW-1:0] ranks,
    input  logic [TW-1:0]           writer,
    output logic [NTHR-1:0]         oldest,
    output logic [NTHR-1:0]         after_writer
);

    // a precedes b when the modular difference a-b is negative
    function automatic logic precedes(input logic [RW-1:0] a, input logic [RW-1:0] b);
        logic [RW-1:0] d;
        d = a - b;
        return d[RW-1];
    endfunction

    for (genvar i = 0; i < NTHR; i++) begin : g_cmp
        always_comb begin
            oldest[i] = live[i];
            for (int j = 0; j < NTHR; j++) begin
                if (j != i && live[j] && precedes(ranks[j], ranks[i]))
                    oldest[i] = 1'b0;
            end
            after_writer[i] = precedes(ranks[writer], ranks[i]);
        end
    end

endmodule

// File: rtl/spec_dep_slot.sv
// One thread slot: lifecycle state machine plus per-word read/write marks.
module spec_dep_slot
    import spec_dep_pkg::*;
#(
    parameter int NADDR = 8,
    parameter int RW    = 8,
    localparam int AW   = $clog2(NADDR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_en,
    input  logic          read_en,
    input  logic          write_en,
    input  logic          ext_write,
    input  logic          writer_before,
    input  logic          release_en,
    input  logic [AW-1:0] addr,
    input  logic          match,
    input  logic [RW-1:0] rank_in,
    output logic          live,
    output logic [RW-1:0] rank,
    output logic          viol
);

    slot_st_t          state_q, state_d;
    logic [NADDR-1:0]  rd_q, rd_d, wr_q, wr_d;
    logic [RW-1:0]     rank_q, rank_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_FREE;
            rd_q    <= '0;
            wr_q    <= '0;
            rank_q  <= '0;
        end else begin
            state_q <= state_d;
            rd_q    <= rd_d;
            wr_q    <= wr_d;
            rank_q  <= rank_d;
        end
    end

    // outputs of the slot
    always_comb begin
        live = (state_q == SL_LIVE);
        rank = rank_q;
        viol = live && ext_write && writer_before && rd_q[addr] && !match;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        rd_d    = rd_q;
        wr_d    = wr_q;
        rank_d  = rank_q;
        unique case (state_q)
            SL_FREE: begin
                if (start_en) begin            // T_START
                    state_d = SL_LIVE;
                    rank_d  = rank_in;
                    rd_d    = '0;
                    wr_d    = '0;
                end
            end
            SL_LIVE: begin
                if (release_en) begin          // T_RETIRE / T_SQUASH
                    state_d = SL_FREE;
                    rd_d    = '0;
                    wr_d    = '0;
                end else if (viol) begin       // T_RESTART
                    rd_d = '0;
                    wr_d = '0;
                end else begin                 // T_TRACK
                    if (read_en && !wr_q[addr]) rd_d[addr] = 1'b1;
                    if (write_en)               wr_d[addr] = 1'b1;
                end
            end
            default: state_d = SL_FREE;
        endcase
    end

endmodule

// File: rtl/spec_dep_tracker.sv
module spec_dep_tracker
    import spec_dep_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int NADDR = 8,
    parameter int RW    = 8,
    localparam int TW   = $clog2(NTHR),
    localparam int AW   = $clog2(NADDR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_kind,
    input  logic [TW-1:0]   op_tid,
    input  logic [AW-1:0]   op_addr,
    input  logic            op_match,
    output logic [NTHR-1:0] live_o,
    output logic [NTHR-1:0] restart_o,
    output logic            commit_ok_o,
    output logic            commit_err_o
);

    logic [NTHR-1:0]         live, oldest, after_writer, viol;
    logic [NTHR-1:0][RW-1:0] ranks;
    logic [RW-1:0]           rank_ctr_q;
    logic                    is_start, is_read, is_write, is_commit, is_squash;
    logic                    grant, started;

    always_comb begin
        is_start  = op_valid && (op_kind == OPK_START);
        is_read   = op_valid && (op_kind == OPK_READ);
        is_write  = op_valid && (op_kind == OPK_WRITE);
        is_commit = op_valid && (op_kind == OPK_COMMIT);
        is_squash = op_valid && (op_kind == OPK_SQUASH);
        grant     = is_commit && live[op_tid] && oldest[op_tid];
        started   = is_start && !live[op_tid];
    end

    spec_dep_order #(.NTHR(NTHR), .RW(RW)) u_order (
        .live         (live),
        .ranks        (ranks),
        .writer       (op_tid),
        .oldest       (oldest),
        .after_writer (after_writer)
    );

    for (genvar i = 0; i < NTHR; i++) begin : g_slot
        logic mine;
        assign mine = (op_tid == TW'(i));
        spec_dep_slot #(.NADDR(NADDR), .RW(RW)) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .start_en      (is_start && mine),
            .read_en       (is_read && mine),
            .write_en      (is_write && mine),
            .ext_write     (is_write && !mine && live[op_tid]),
            .writer_before (after_writer[i]),
            .release_en    ((grant || is_squash) && mine),
            .addr          (op_addr),
            .match         (op_match),
            .rank_in       (rank_ctr_q),
            .live          (live[i]),
            .rank          (ranks[i]),
            .viol          (viol[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_ctr_q   <= '0;
            restart_o    <= '0;
            commit_ok_o  <= 1'b0;
            commit_err_o <= 1'b0;
        end else begin
            if (started) rank_ctr_q <= rank_ctr_q + 1'b1;
            restart_o    <= viol;
            commit_ok_o  <= grant;
            commit_err_o <= is_commit && !grant;
        end
    end

    assign live_o = live;

endmodule

// File: rtl/spec_dep_chk.sv
module spec_dep_chk #(
    parameter int NTHR = 4,
    localparam int TW  = $clog2(NTHR)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_valid,
    input logic [2:0]      op_kind,
    input logic [NTHR-1:0] live_o,
    input logic [NTHR-1:0] restart_o,
    input logic            commit_ok_o,
    input logic            commit_err_o
);

    // R3: a restarted slot was live before and remains live
    p_restart_was_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o != '0) |-> (($past(live_o) & restart_o) == restart_o));
    p_restart_stays_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o != '0) |-> ((live_o & restart_o) == restart_o));
    // R8: a granted commit removes exactly one live slot
    p_commit_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok_o |-> ($countones(live_o) + 1 == $countones($past(live_o))));
    // R9: refused commit leaves slots unchanged
    p_commit_err_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_err_o |-> $stable(live_o));
    // R8 / R9: grant and refusal never together
    p_ok_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_ok_o && commit_err_o));
    // R4: only writes can cause restarts
    p_write_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_kind == 3'd3) |=> (restart_o == '0));

endmodule

bind spec_dep_tracker spec_dep_chk #(.NTHR(NTHR)) u_spec_dep_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .live_o       (live_o),
    .restart_o    (restart_o),
    .commit_ok_o  (commit_ok_o),
    .commit_err_o (commit_err_o)
);

// File: tb/test_spec_dep_tracker.sv
module test_spec_dep_tracker;
    localparam int NTHR  = 4;
    localparam int NADDR = 8;

    logic       clk = 0, rst_n = 0;
    logic       op_valid = 0, op_match = 0;
    logic [2:0] op_kind = 0;
    logic [1:0] op_tid = 0;
    logic [2:0] op_addr = 0;
    logic [3:0] live_o, restart_o;
    logic       commit_ok_o, commit_err_o;

    int errors = 0, checks = 0;

    // bench model
    bit m_live [NTHR];
    int m_rank [NTHR];
    bit m_rd   [NTHR][NADDR];
    bit m_wr   [NTHR][NADDR];
    int m_ctr = 0;
    logic [3:0] e_live, e_rst;
    bit e_ok, e_err;

    always #10 clk = ~clk;   // 50 MHz

    spec_dep_tracker i_spec_dep_tracker (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_tid(op_tid), .op_addr(op_addr), .op_match(op_match),
        .live_o(live_o), .restart_o(restart_o),
        .commit_ok_o(commit_ok_o), .commit_err_o(commit_err_o));

    function automatic bit is_oldest(int t);
        if (!m_live[t]) return 0;
        for (int j = 0; j < NTHR; j++)
            if (j != t && m_live[j] && m_rank[j] < m_rank[t]) return 0;
        return 1;
    endfunction

    function automatic void model_step(int k, int t, int a, bit mt);
        e_rst = '0; e_ok = 0; e_err = 0;
        case (k)
            1: if (!m_live[t]) begin
                   m_live[t] = 1; m_rank[t] = m_ctr; m_ctr++;
                   for (int i = 0; i < NADDR; i++) begin m_rd[t][i] = 0; m_wr[t][i] = 0; end
               end
            2: if (m_live[t] && !m_wr[t][a]) m_rd[t][a] = 1;
            3: if (m_live[t]) begin
                   for (int s = 0; s < NTHR; s++)
                       if (s != t && m_live[s] && m_rank[t] < m_rank[s] && m_rd[s][a] && !mt) begin
                           e_rst[s] = 1;
                           for (int i = 0; i < NADDR; i++) begin m_rd[s][i] = 0; m_wr[s][i] = 0; end
                       end
                   m_wr[t][a] = 1;
               end
            4: if (is_oldest(t)) begin e_ok = 1; m_live[t] = 0; end
               else e_err = 1;
            5: m_live[t] = 0;
            default: ;
        endcase
        for (int s = 0; s < NTHR; s++) e_live[s] = m_live[s];
    endfunction

    task automatic op(int k, int t, int a, bit mt, string req);
        op_valid = (k != 0); op_kind = 3'(k); op_tid = 2'(t);
        op_addr = 3'(a); op_match = mt;
        model_step(k, t, a, mt);
        @(negedge clk);
        checks++;
        if (live_o !== e_live || restart_o !== e_rst ||
            commit_ok_o !== e_ok || commit_err_o !== e_err) begin
            errors++;
            $display("FAIL %s: live=%b restart=%b ok=%b err=%b expected live=%b restart=%b ok=%b err=%b",
                     req, live_o, restart_o, commit_ok_o, commit_err_o, e_live, e_rst, e_ok, e_err);
        end
        op_valid = 0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        op(0, 0, 0, 0, "R1");                 // reset state
        // R2 starts
        op(1, 0, 0, 0, "R2"); op(1, 1, 0, 0, "R2"); op(1, 2, 0, 0, "R2");
        op(1, 1, 0, 0, "R2");                 // already live: no effect
        // R3 basic violation: slot1 reads 4, slot0 writes 4
        op(2, 1, 4, 0, "R3"); op(3, 0, 4, 0, "R3"); op(0, 0, 0, 0, "R3");
        // R6 second write does not re-flag
        op(3, 0, 4, 0, "R6");
        // R4 anti: slot0 reads 5, slot2 writes 5
        op(2, 0, 5, 0, "R4"); op(3, 2, 5, 0, "R4");
        // R5 own write first
        op(3, 2, 6, 0, "R5"); op(2, 2, 6, 0, "R5"); op(3, 0, 6, 0, "R5");
        // R7 match suppression
        op(2, 2, 1, 0, "R7"); op(3, 1, 1, 1, "R7");
        // R3 multi-slot violation
        op(2, 1, 2, 0, "R3"); op(2, 2, 2, 0, "R3"); op(3, 0, 2, 0, "R3");
        // R9 commit not oldest / free slot
        op(4, 2, 0, 0, "R9"); op(4, 3, 0, 0, "R9");
        // R11 ops on free slot 3
        op(2, 3, 3, 0, "R11"); op(3, 3, 3, 0, "R11");
        op(2, 2, 3, 0, "R11"); op(3, 3, 3, 0, "R11");
        // R8 commit oldest
        op(4, 0, 0, 0, "R8"); op(4, 1, 0, 0, "R8");
        // R10 squash without restart
        op(2, 2, 7, 0, "R10"); op(5, 2, 0, 0, "R10"); op(0, 0, 0, 0, "R10");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int k, t, a; bit mt, forced;
            forced = 0;
            for (int s = 0; s < NTHR; s++)
                if (!forced && m_live[s] && m_rank[s] < m_ctr - 60) begin
                    op(5, s, 0, 0, "R10"); forced = 1;
                end
            if (!forced) begin
                k  = 1 + int'($urandom_range(4, 0));
                t  = int'($urandom_range(NTHR - 1, 0));
                a  = int'($urandom_range(NADDR - 1, 0));
                mt = ($urandom_range(7, 0) == 0);
                op(k, t, a, mt, k == 3 ? "R3" : k == 4 ? "R8" : k == 1 ? "R2" : "R11");
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule